// File: doc/BRIEF.md
# Parallel Port With Timer Overlay

This block holds two 8-bit bidirectional ports, A and B. Each port has a data register and a direction register. Software reaches them through a 4-bit register address. A pin is driven from its data register wherever its direction bit is 1, and is released to high impedance otherwise. Reading a port returns the data register value with every input bit forced to 1. There is no model of external pull-ups or of what is driven onto the pins from outside.

The block also holds the two timer control registers. It does not count. The timer cores outside the block supply two things to it: their output levels and their live running state. When a control register asks for it, the timer output levels replace port B bits 6 and 7 on a read. Timer A maps to bit 6 and timer B to bit 7. A write that raises a control register's start bit from 0 to 1 sends a one-cycle pulse back to that timer, which sets its toggle flip-flop high. A read of a control register shows the live running state in bit 0 and hides bit 4. Any address with no defined function acts as plain read/write storage.

Top module: `pio_tmr_overlay`

## Requirements
- R1: A write is captured at the rising clock edge that samples `wr_en`. `rd_data` is combinational from `addr` and the stored state, so it still shows the old value up to that edge.
- R2: A read of address 0 returns port A data OR the inverse of port A direction (address 2), so input bits read as 1.
- R3: A read of address 1 returns port B data OR the inverse of port B direction (address 3). When bit 1 of control A (address 14) is set, bit 6 of that read equals `tmr_a_lvl`.
- R4: When bit 1 of control B (address 15) is set, bit 7 of a port B read equals `tmr_b_lvl`. When that bit is clear, bit 7 follows the register rule of R3.
- R5: `pa_drv` and `pb_drv` carry the data registers. `pa_oe` and `pb_oe` carry the direction registers, and a 1 means the pin is driven.
- R6: A write to address 14 or 15 whose bit 0 is 1 while the stored bit 0 is 0 raises `tgl_rst_a` or `tgl_rst_b` for exactly the next cycle. A write that leaves bit 0 at 1 gives no pulse.
- R7: A read of address 14 or 15 returns the stored control value with bits 4 and 0 cleared, ORed in bit 0 with `tmr_a_run` or `tmr_b_run`.
- R8: Addresses 4 to 13 return the last value written to that same address, and writes to other addresses leave them unchanged.
- R9: An active-low reset clears every register to zero. After reset, port reads return 0xFF, storage reads return 0x00, and the pins are not driven.
- R10: The timer overlay acts only on reads. `pb_drv` never shows the timer levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| tmr_a_lvl | input | 1 | Timer A output level |
| tmr_b_lvl | input | 1 | Timer B output level |
| tmr_a_run | input | 1 | Timer A running state |
| tmr_b_run | input | 1 | Timer B running state |
| tgl_rst_a | output | 1 | Pulse that sets timer A's toggle flip-flop high |
| tgl_rst_b | output | 1 | Pulse that sets timer B's toggle flip-flop high |
| pa_drv | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_drv | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B pin drive enables |

## Verification
Register contents, pin drives and the toggle pulses all change at the same rising edge that samples the write. Read data and the timer overlay bits follow `addr` and the timer inputs with no delay. The bench drives every input on the falling edge and samples one nanosecond later. A read therefore reflects the write from half a cycle before, and a toggle pulse is observed in the one low phase where it must be high and in the next low phase where it must be low again. One check samples before the capturing edge to show that a write is not visible early.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;
  localparam int PDW = 8;
  localparam int PAW = 4;

  localparam logic [PAW-1:0] ADR_PA_DATA = 4'd0;
  localparam logic [PAW-1:0] ADR_PB_DATA = 4'd1;
  localparam logic [PAW-1:0] ADR_PA_DIR  = 4'd2;
  localparam logic [PAW-1:0] ADR_PB_DIR  = 4'd3;
  localparam logic [PAW-1:0] ADR_CTL_A   = 4'd14;
  localparam logic [PAW-1:0] ADR_CTL_B   = 4'd15;

  localparam int CTL_START  = 0;
  localparam int CTL_OVL_EN = 1;
  localparam int CTL_HIDDEN = 4;
  localparam int OVL_BIT_A  = 6;
  localparam int OVL_BIT_B  = 7;

  // Undriven bits read as 1.
  function automatic logic [PDW-1:0] dir_view(input logic [PDW-1:0] data,
                                              input logic [PDW-1:0] dir);
    return data | ~dir;
  endfunction

  // Control readback: hidden bits removed, live state shown in the start bit.
  function automatic logic [PDW-1:0] ctl_view(input logic [PDW-1:0] ctl,
                                              input logic run);
    logic [PDW-1:0] v;
    v = ctl;
    v[CTL_HIDDEN] = 1'b0;
    v[CTL_START]  = run;
    return v;
  endfunction

  // Replace port B bits with timer levels when enabled.
  function automatic logic [PDW-1:0] pb_overlay(input logic [PDW-1:0] v,
                                                input logic en_a, input logic lvl_a,
                                                input logic en_b, input logic lvl_b);
    logic [PDW-1:0] r;
    r = v;
    if (en_a) r[OVL_BIT_A] = lvl_a;
    if (en_b) r[OVL_BIT_B] = lvl_b;
    return r;
  endfunction

  function automatic logic is_storage(input logic [PAW-1:0] a);
    return (a > ADR_PB_DIR) && (a < ADR_CTL_A);
  endfunction
endpackage

// File: rtl/pio_port_bank.sv
module pio_port_bank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end
endmodule

// File: rtl/pio_start_detect.sv
module pio_start_detect #(
  parameter int DW = 8,
  parameter int START_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic          start_pulse
);
  logic start_edge;

  assign start_edge = wr_ctl && wdata[START_BIT] && !ctl_q[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= start_edge;
      if (wr_ctl) ctl_q <= wdata;
    end
  end
endmodule

// File: rtl/pio_storage.sv
module pio_storage #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  import pio_tmr_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    localparam logic [AW-1:0] LOC = AW'(i);
    if (is_storage(LOC)) begin : g_used
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '0;
        else if (wr_en && waddr == LOC) mem[i] <= wdata;
      end
    end else begin : g_unused
      assign mem[i] = '0;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pio_tmr_overlay.sv
module pio_tmr_overlay #(
  parameter int DW = pio_tmr_pkg::PDW,
  parameter int AW = pio_tmr_pkg::PAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  input  logic          tmr_a_lvl,
  input  logic          tmr_b_lvl,
  input  logic          tmr_a_run,
  input  logic          tmr_b_run,
  output logic          tgl_rst_a,
  output logic          tgl_rst_b,
  output logic [DW-1:0] pa_drv,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] pb_drv,
  output logic [DW-1:0] pb_oe
);
  import pio_tmr_pkg::*;
  localparam int NPORT = 2;
  localparam int NTMR  = 2;

  logic [DW-1:0] p_data [NPORT];
  logic [DW-1:0] p_dir  [NPORT];
  logic [DW-1:0] ctl_q  [NTMR];
  logic [NTMR-1:0] start_pulse;
  logic [DW-1:0] store_rd;

  // Named events for the checker.
  logic [DW-1:0] ctl_a_q, ctl_b_q;
  logic          ovl_a_en, ovl_b_en;

  localparam logic [AW-1:0] DATA_ADR [NPORT] = '{ADR_PA_DATA, ADR_PB_DATA};
  localparam logic [AW-1:0] DIR_ADR  [NPORT] = '{ADR_PA_DIR, ADR_PB_DIR};
  localparam logic [AW-1:0] CTL_ADR  [NTMR]  = '{ADR_CTL_A, ADR_CTL_B};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port_bank #(.DW(DW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_data(wr_en && addr == DATA_ADR[p]),
      .wr_dir (wr_en && addr == DIR_ADR[p]),
      .wdata  (wdata),
      .data_q (p_data[p]),
      .dir_q  (p_dir[p])
    );
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    pio_start_detect #(.DW(DW), .START_BIT(CTL_START)) u_start (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctl     (wr_en && addr == CTL_ADR[t]),
      .wdata      (wdata),
      .ctl_q      (ctl_q[t]),
      .start_pulse(start_pulse[t])
    );
  end

  pio_storage #(.AW(AW), .DW(DW)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .waddr(addr),
    .wdata(wdata),
    .raddr(addr),
    .rdata(store_rd)
  );

  assign ctl_a_q  = ctl_q[0];
  assign ctl_b_q  = ctl_q[1];
  assign ovl_a_en = ctl_a_q[CTL_OVL_EN];
  assign ovl_b_en = ctl_b_q[CTL_OVL_EN];

  assign pa_drv    = p_data[0];
  assign pa_oe     = p_dir[0];
  assign pb_drv    = p_data[1];
  assign pb_oe     = p_dir[1];
  assign tgl_rst_a = start_pulse[0];
  assign tgl_rst_b = start_pulse[1];

  always_comb begin
    unique case (addr)
      ADR_PA_DATA: rd_data = dir_view(p_data[0], p_dir[0]);
      ADR_PB_DATA: rd_data = pb_overlay(dir_view(p_data[1], p_dir[1]),
                                        ovl_a_en, tmr_a_lvl, ovl_b_en, tmr_b_lvl);
      ADR_PA_DIR:  rd_data = p_dir[0];
      ADR_PB_DIR:  rd_data = p_dir[1];
      ADR_CTL_A:   rd_data = ctl_view(ctl_a_q, tmr_a_run);
      ADR_CTL_B:   rd_data = ctl_view(ctl_b_q, tmr_b_run);
      default:     rd_data = store_rd;
    endcase
  end
endmodule

// File: rtl/pio_tmr_overlay_chk.sv
module pio_tmr_overlay_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rd_data,
  input logic          tmr_a_lvl,
  input logic          tmr_b_lvl,
  input logic          tmr_a_run,
  input logic          tgl_rst_a,
  input logic          tgl_rst_b,
  input logic [DW-1:0] pa_drv,
  input logic [DW-1:0] pa_oe,
  input logic          ovl_a_en,
  input logic          ovl_b_en
);
  import pio_tmr_pkg::*;

  a_r2_pa_read: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_PA_DATA) |-> rd_data == (pa_drv | ~pa_oe));

  a_r3_pb6_overlay: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_PB_DATA && ovl_a_en) |-> rd_data[OVL_BIT_A] == tmr_a_lvl);

  a_r4_pb7_overlay: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_PB_DATA && ovl_b_en) |-> rd_data[OVL_BIT_B] == tmr_b_lvl);

  a_r5_dir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_PA_DIR) |=> pa_oe == $past(wdata));

  a_r6_pulse_cause_a: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_rst_a |-> $past(wr_en && addr == ADR_CTL_A && wdata[CTL_START]));

  a_r6_single_a: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_rst_a |=> !tgl_rst_a);

  a_r6_single_b: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_rst_b |=> !tgl_rst_b);

  a_r7_ctl_view: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTL_A) |-> (rd_data[CTL_START] == tmr_a_run && !rd_data[CTL_HIDDEN]));
endmodule

bind pio_tmr_overlay pio_tmr_overlay_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .rd_data  (rd_data),
  .tmr_a_lvl(tmr_a_lvl),
  .tmr_b_lvl(tmr_b_lvl),
  .tmr_a_run(tmr_a_run),
  .tgl_rst_a(tgl_rst_a),
  .tgl_rst_b(tgl_rst_b),
  .pa_drv   (pa_drv),
  .pa_oe    (pa_oe),
  .ovl_a_en (ovl_a_en),
  .ovl_b_en (ovl_b_en)
);

// File: tb/pio_tmr_overlay_bench.sv
module pio_tmr_overlay_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       tmr_a_lvl = 1'b0, tmr_b_lvl = 1'b0, tmr_a_run = 1'b0, tmr_b_run = 1'b0;
  logic       tgl_rst_a, tgl_rst_b;
  logic [7:0] pa_drv, pa_oe, pb_drv, pb_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pio_tmr_overlay u_pio_tmr_overlay (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .tmr_a_lvl(tmr_a_lvl), .tmr_b_lvl(tmr_b_lvl),
    .tmr_a_run(tmr_a_run), .tmr_b_run(tmr_b_run),
    .tgl_rst_a(tgl_rst_a), .tgl_rst_b(tgl_rst_b),
    .pa_drv(pa_drv), .pa_oe(pa_oe), .pb_drv(pb_drv), .pb_oe(pb_oe));

  // {write addr, write data, timer inputs {a_lvl,b_lvl,a_run,b_run}, read addr, expected}
  localparam logic [27:0] VEC [16] = '{
    {4'd0,  8'hA5, 4'b0000, 4'd0,  8'hFF},  // R2
    {4'd2,  8'h0F, 4'b0000, 4'd0,  8'hF5},  // R2
    {4'd2,  8'hFF, 4'b0000, 4'd0,  8'hA5},  // R2
    {4'd1,  8'h3C, 4'b0000, 4'd1,  8'hFF},  // R3
    {4'd3,  8'hF0, 4'b0000, 4'd1,  8'h3F},  // R3
    {4'd14, 8'h02, 4'b1000, 4'd1,  8'h7F},  // R3
    {4'd14, 8'h02, 4'b0000, 4'd1,  8'h3F},  // R3
    {4'd15, 8'h02, 4'b0100, 4'd1,  8'hBF},  // R4
    {4'd15, 8'h02, 4'b1000, 4'd1,  8'h7F},  // R4
    {4'd14, 8'hFF, 4'b0010, 4'd14, 8'hEF},  // R7
    {4'd14, 8'hFF, 4'b0000, 4'd14, 8'hEE},  // R7
    {4'd15, 8'h11, 4'b0000, 4'd15, 8'h00},  // R7
    {4'd7,  8'h5A, 4'b0000, 4'd7,  8'h5A},  // R8
    {4'd13, 8'hC3, 4'b0000, 4'd7,  8'h5A},  // R8
    {4'd13, 8'hC3, 4'b0000, 4'd13, 8'hC3},  // R8
    {4'd4,  8'h00, 4'b1100, 4'd1,  8'h7F}   // R4 overlay off for bit 7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    rd_chk("R9", 4'd2, 8'h00);
    chk("R9", {7'd0, tgl_rst_a}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R9", 4'd0, 8'hFF);

    for (int i = 0; i < 16; i++) begin
      wr(VEC[i][27:24], VEC[i][23:16]);
      {tmr_a_lvl, tmr_b_lvl, tmr_a_run, tmr_b_run} = VEC[i][15:12];
      rd_chk($sformatf("R2-table-%0d", i), VEC[i][11:8], VEC[i][7:0]);
    end

    // R5, R10: pin drive follows registers, overlay absent (a_lvl=b_lvl=1 here)
    chk("R5", pa_drv, 8'hA5);
    chk("R5", pa_oe, 8'hFF);
    chk("R10", pb_drv, 8'h3C);
    chk("R5", pb_oe, 8'hF0);

    // R1: write not visible before its capturing edge
    @(negedge clk);
    addr = 4'd7; wdata = 8'h99; wr_en = 1'b1;
    #1 chk("R1", rd_data, 8'h5A);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R1", rd_data, 8'h99);

    // R6: start edge pulses on control A (currently 0xFF)
    wr(4'd14, 8'h00);
    #1 chk("R6", {7'd0, tgl_rst_a}, 8'h00);
    wr(4'd14, 8'h01);
    #1 chk("R6", {6'd0, tgl_rst_b, tgl_rst_a}, 8'h01);
    @(negedge clk);
    #1 chk("R6", {7'd0, tgl_rst_a}, 8'h00);
    wr(4'd14, 8'h01);
    #1 chk("R6", {7'd0, tgl_rst_a}, 8'h00);
    // control B currently 0x11: bit0 already set
    wr(4'd15, 8'h01);
    #1 chk("R6", {7'd0, tgl_rst_b}, 8'h00);
    wr(4'd15, 8'h00);
    wr(4'd15, 8'h01);
    #1 chk("R6", {6'd0, tgl_rst_b, tgl_rst_a}, 8'h02);

    // R9: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tmr_a_lvl = 1'b0; tmr_b_lvl = 1'b0; tmr_a_run = 1'b1; tmr_b_run = 1'b0;
    @(negedge clk);
    rd_chk("R9", 4'd0, 8'hFF);
    rd_chk("R9", 4'd1, 8'hFF);
    rd_chk("R9", 4'd7, 8'h00);
    rd_chk("R9", 4'd14, 8'h01);
    chk("R9", pa_oe, 8'h00);
    chk("R9", pb_drv, 8'h00);

    finish_run();
  end
endmodule